// File: doc/BRIEF.md
# Cascadable Backplane Phase Synchronizer

This block sequences the backplane phases of a multiplexed segment display driver. It divides the display clock into phases of `PHASE_CYCLES` clocks. It reports which backplane is active and pulses a strobe as each phase opens. Several copies share one active-low, wired-AND SYNC line. A copy pulls the line low for the whole of its last active phase and only listens to it during the other phases.

One copy is strapped as the master. It is the timing reference and never changes its own phase. The other copies are slaves. A slave that sees the line pulled low by someone else, in a phase where it is not pulling the line itself, moves its phase counter so that it agrees with the device that pulled first. The line is sampled through a two-flop synchronizer. The slave corrects its counter for that sampling delay, so it lands on exactly the same clock as the device that pulled the line.

Copies released from reset together stay aligned without any SYNC activity. Analog backplane voltages and segment data are handled elsewhere.

Top module: `bpPhaseSync`

## Requirements
- R1: While reset is held and in the first clock after it is released, `bpIndex` is 0 and `phaseStrobe` is 1. Two copies released on the same clock then report the same index, strobe and drive on every cycle.
- R2: Every phase lasts `PHASE_CYCLES` clocks. The index counts 0, 1, … up to the last active index and then returns to 0. The last active index equals `muxMode`: 2'b00 static (index 0 only), 2'b01 two phases, 2'b10 three phases, 2'b11 four phases.
- R3: `phaseStrobe` is 1 in the first clock of each phase that is reached by counting, and 0 in every other clock of an undisturbed run.
- R4: `syncDriveEn` (1 means pull the line low) is 1 exactly while the index equals the last active index. That is one phase per frame, and continuous in static mode.
- R5: `syncSense` is 1 exactly when the line (`syncIn`) was low at the clock edge two cycles earlier, counted from the second clock after reset.
- R6: A slave (`isMaster`=0) realigns when the synchronized line is low and the slave was not driving it at that time. This applies when, one sample earlier, the line was high or the slave itself was driving. The slave then enters its last active phase three clocks into that phase, which matches the device that pulled the line.
- R7: A master (`isMaster`=1) never changes its phase because of the line. Its index, strobe and drive follow R2 to R4 from its own reset, whatever the other devices do.
- R8: A master and a slave with `muxMode` of 01, 10 or 11 report identical index, strobe and drive from three frames after the later of the two resets is released, whatever the offset between those resets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Display clock, shared by all cascaded copies |
| rstN | input | 1 | Asynchronous active-low reset |
| muxMode | input | 2 | Multiplex mode; its value is the last active backplane index |
| isMaster | input | 1 | Strap: 1 for the cascade master, 0 for a slave |
| syncIn | input | 1 | Level of the shared wired-AND SYNC line, low when asserted |
| bpIndex | output | 2 | Currently active backplane |
| phaseStrobe | output | 1 | High in the first clock of a counted phase |
| syncDriveEn | output | 1 | 1 to pull the SYNC line low |
| syncSense | output | 1 | Synchronized SYNC line, 1 when it was seen low |

## Verification
The phase counter is first run with two copies released together in every multiplex mode. This shows the counting pattern, the drive window and the static case, and confirms that a reset alone keeps copies aligned. Skewed runs then release the slave at offsets drawn from a seeded random source. Directed offsets are added: exactly one phase late, a few clocks late, a couple of clocks early, and exactly one frame late. These produce the three ways the two drive windows can meet: separated, touching, and overlapping with either copy first. Each is a different path through the realignment logic. During the skewed runs the master is checked against its own counting model, which shows that it is never pulled away by the slave.

// File: rtl/bpsync_pkg.sv
package bpsync_pkg;

  localparam int IDX_W = 2;       // up to four backplanes
  localparam int SYNC_LAT = 3;    // clocks from line edge to realign decision

  typedef enum logic [1:0] {
    MUX_STATIC = 2'b00,
    MUX_TWO    = 2'b01,
    MUX_THREE  = 2'b10,
    MUX_FOUR   = 2'b11
  } muxMode_e;

  typedef struct packed {
    logic realign;   // jump to last phase, prescaler at SYNC_LAT
    logic lineLow;   // synchronized line level, 1 = low
  } ctrlStrobes_t;

endpackage

// File: rtl/bpSyncCtrl.sv
module bpSyncCtrl
  import bpsync_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         isMaster,
  input  logic         syncIn,
  input  logic         driveLow,
  output ctrlStrobes_t strobes,
  output logic         syncSense
);

  logic [1:0] syncFf;      // two-flop synchronizer, [1] is the stable sample
  logic       syncPrev;    // stable sample one cycle older
  logic [2:0] drvPipe;     // own drive history, aligned with the samples

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncFf   <= 2'b11;
      syncPrev <= 1'b1;
      drvPipe  <= '0;
    end else begin
      syncFf   <= {syncFf[0], syncIn};
      syncPrev <= syncFf[1];
      drvPipe  <= {drvPipe[1:0], driveLow};
    end
  end

  // drvPipe[1] is own drive when syncFf[1] was taken, drvPipe[2] matches syncPrev
  logic foreignLow;
  logic freshLow;

  always_comb begin
    foreignLow = !syncFf[1] && !drvPipe[1];
    freshLow   = syncPrev || drvPipe[2];
    strobes.realign = !isMaster && foreignLow && freshLow;
    strobes.lineLow = !syncFf[1];
  end

  assign syncSense = !syncFf[1];

endmodule

// File: rtl/bpPhaseDatapath.sv
module bpPhaseDatapath
  import bpsync_pkg::*;
#(
  parameter int PHASE_CYCLES = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] lastIdx,
  input  ctrlStrobes_t     strobes,
  output logic [IDX_W-1:0] bpIndex,
  output logic             phaseStrobe,
  output logic             driveLow
);

  localparam int PW = (PHASE_CYCLES > 1) ? $clog2(PHASE_CYCLES) : 1;
  localparam logic [PW-1:0] PRESC_LAST = PW'(PHASE_CYCLES - 1);
  localparam logic [PW-1:0] PRESC_LOAD = PW'(SYNC_LAT);

  logic [PW-1:0]    presc;
  logic             phaseEnd;
  logic [IDX_W-1:0] nextIdx;

  always_comb begin
    phaseEnd = (presc == PRESC_LAST);
    if (bpIndex >= lastIdx) nextIdx = '0;
    else                    nextIdx = bpIndex + 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      presc   <= '0;
      bpIndex <= '0;
    end else if (strobes.realign) begin
      presc   <= PRESC_LOAD;
      bpIndex <= lastIdx;
    end else if (phaseEnd) begin
      presc   <= '0;
      bpIndex <= nextIdx;
    end else begin
      presc   <= presc + 1'b1;
    end
  end

  assign phaseStrobe = (presc == '0);
  assign driveLow    = (bpIndex == lastIdx);

endmodule

// File: rtl/bpPhaseSync.sv
module bpPhaseSync
  import bpsync_pkg::*;
#(
  parameter int PHASE_CYCLES = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] muxMode,
  input  logic       isMaster,
  input  logic       syncIn,
  output logic [1:0] bpIndex,
  output logic       phaseStrobe,
  output logic       syncDriveEn,
  output logic       syncSense
);

  ctrlStrobes_t strobes;
  logic         driveLow;

  bpSyncCtrl u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .isMaster  (isMaster),
    .syncIn    (syncIn),
    .driveLow  (driveLow),
    .strobes   (strobes),
    .syncSense (syncSense)
  );

  bpPhaseDatapath #(.PHASE_CYCLES(PHASE_CYCLES)) u_dp (
    .clk         (clk),
    .rstN        (rstN),
    .lastIdx     (muxMode),
    .strobes     (strobes),
    .bpIndex     (bpIndex),
    .phaseStrobe (phaseStrobe),
    .driveLow    (driveLow)
  );

  assign syncDriveEn = driveLow;

endmodule

// File: rtl/bpPhaseSync_chk.sv
module bpPhaseSync_chk #(
  parameter int PHASE_CYCLES = 8
) (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] muxMode,
  input logic       isMaster,
  input logic       syncIn,
  input logic [1:0] bpIndex,
  input logic       phaseStrobe,
  input logic       syncDriveEn,
  input logic       syncSense
);

  localparam int RW = $clog2(PHASE_CYCLES + 2);

  logic [1:0]    sinceRst;
  logic [RW-1:0] runLen;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sinceRst <= '0;
      runLen   <= '0;
    end else begin
      if (sinceRst != 2'd3) sinceRst <= sinceRst + 1'b1;
      if (!syncDriveEn || (muxMode != $past(muxMode))) runLen <= '0;
      else if (runLen != {RW{1'b1}}) runLen <= runLen + 1'b1;
    end
  end

  initial begin
    AST_PHASE_LONG_ENOUGH: assert (PHASE_CYCLES > 3); // R6
  end

  AST_STROBE_ADVANCES: assert property (@(posedge clk) disable iff (!rstN)
    (phaseStrobe && !$past(phaseStrobe) && muxMode != 2'b00 && $stable(muxMode))
      |-> bpIndex != $past(bpIndex)); // R3

  AST_INDEX_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    (phaseStrobe && $stable(muxMode)) |-> bpIndex <= muxMode); // R2

  AST_SENSE_LATENCY: assert property (@(posedge clk) disable iff (!rstN)
    (sinceRst == 2'd3) |-> (syncSense == !$past(syncIn, 2))); // R5

  AST_MASTER_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && !phaseStrobe) |-> $stable(bpIndex)); // R7

  AST_MASTER_DRIVE_LEN: assert property (@(posedge clk) disable iff (!rstN)
    (isMaster && syncDriveEn && muxMode != 2'b00) |-> (runLen < RW'(PHASE_CYCLES))); // R4

endmodule

bind bpPhaseSync bpPhaseSync_chk #(.PHASE_CYCLES(PHASE_CYCLES)) u_chk (
  .clk         (clk),
  .rstN        (rstN),
  .muxMode     (muxMode),
  .isMaster    (isMaster),
  .syncIn      (syncIn),
  .bpIndex     (bpIndex),
  .phaseStrobe (phaseStrobe),
  .syncDriveEn (syncDriveEn),
  .syncSense   (syncSense)
);

// File: tb/bpPhaseSync_bench.sv
module bpPhaseSync_bench;

  localparam int CLK_PERIOD = 10;
  localparam int PC = 8;

  logic       clk = 1'b0;
  logic       rstMN = 1'b0;
  logic       rstSN = 1'b0;
  logic [1:0] muxMode = 2'b11;
  logic [1:0] idxM, idxS;
  logic       strobeM, strobeS, drvM, drvS, senseM, senseS;
  logic       line;

  int nChecks = 0;
  int nFails = 0;

  assign line = !(drvM || drvS);

  always #(CLK_PERIOD / 2) clk = !clk;

  bpPhaseSync #(.PHASE_CYCLES(PC)) u_bpPhaseSync (
    .clk(clk), .rstN(rstMN), .muxMode(muxMode), .isMaster(1'b1), .syncIn(line),
    .bpIndex(idxM), .phaseStrobe(strobeM), .syncDriveEn(drvM), .syncSense(senseM)
  );

  bpPhaseSync #(.PHASE_CYCLES(PC)) u_bpPhaseSyncSlave (
    .clk(clk), .rstN(rstSN), .muxMode(muxMode), .isMaster(1'b0), .syncIn(line),
    .bpIndex(idxS), .phaseStrobe(strobeS), .syncDriveEn(drvS), .syncSense(senseS)
  );

  function automatic int expIdx(input int k, input logic [1:0] mode);
    return (k / PC) % (int'(mode) + 1);
  endfunction

  function automatic logic expStrobe(input int k);
    return (k % PC) == 0;
  endfunction

  function automatic logic expDrive(input int k, input logic [1:0] mode);
    return expIdx(k, mode) == int'(mode);
  endfunction

  task automatic check(input logic ok, input string req, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s at %0t: actual %0d expected %0d", req, $time, act, exp);
    end
  endtask

  task automatic holdReset(input logic [1:0] mode);
    rstMN = 1'b0;
    rstSN = 1'b0;
    muxMode = mode;
    repeat (3) @(negedge clk);
    check(idxM == 2'd0, "R1 reset index", int'(idxM), 0);
    check(strobeM == 1'b1, "R1 reset strobe", int'(strobeM), 1);
  endtask

  task automatic runAligned(input logic [1:0] mode, input int cycles);
    logic h1 = 1'b0;
    logic h2 = 1'b0;
    holdReset(mode);
    rstMN = 1'b1;
    rstSN = 1'b1;
    for (int k = 0; k < cycles; k++) begin
      if (k > 0) @(negedge clk);
      check(int'(idxM) == expIdx(k, mode), "R2 index", int'(idxM), expIdx(k, mode));
      check(strobeM == expStrobe(k), "R3 strobe", int'(strobeM), int'(expStrobe(k)));
      check(drvM == expDrive(k, mode), "R4 drive", int'(drvM), int'(expDrive(k, mode)));
      check(idxS == idxM && strobeS == strobeM && drvS == drvM, "R1 joint release",
            int'(idxS), int'(idxM));
      if (k >= 2) check(senseM == h2, "R5 sense", int'(senseM), int'(h2));
      h2 = h1;
      h1 = !line;
    end
  endtask

  task automatic runSkewed(input logic [1:0] mode, input int offset);
    int frame = PC * (int'(mode) + 1);
    int settle = offset + 3 * frame;
    holdReset(mode);
    rstMN = 1'b1;
    for (int k = 0; k < settle + 2 * frame; k++) begin
      if (k > 0) @(negedge clk);
      if (k == offset) rstSN = 1'b1;
      check(int'(idxM) == expIdx(k, mode), "R7 master index", int'(idxM), expIdx(k, mode));
      check(strobeM == expStrobe(k), "R7 master strobe", int'(strobeM), int'(expStrobe(k)));
      if (k >= settle) begin
        check(idxS == idxM, "R8 slave index", int'(idxS), int'(idxM));
        check(strobeS == strobeM, "R8 slave strobe", int'(strobeS), int'(strobeM));
        check(drvS == drvM, "R6 slave drive", int'(drvS), int'(drvM));
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    runAligned(2'b11, 5 * 4 * PC);
    runAligned(2'b10, 4 * 3 * PC);
    runAligned(2'b01, 4 * 2 * PC);
    runAligned(2'b00, 3 * PC);
    // directed skews: one phase late, a few clocks late, slave first, one frame late
    runSkewed(2'b11, PC);
    runSkewed(2'b11, 3);
    runSkewed(2'b11, 4 * PC - 2);
    runSkewed(2'b11, 4 * PC);
    runSkewed(2'b01, PC + 1);
    runSkewed(2'b10, 2 * PC);
    for (int n = 0; n < 8; n++) begin
      logic [1:0] m = 2'($urandom_range(1, 3));
      runSkewed(m, int'($urandom_range(1, 2 * PC * (int'(m) + 1))));
    end
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule